// File: doc/BRIEF.md
# Wide MixColumns with Sub-Matrix Signatures

This block applies the AES column mixing to a 2048-bit state. The state holds 4 rows of 64 byte columns. It is handled as sixteen independent groups of four adjacent columns. Every column is multiplied by the fixed AES MixColumns matrix over GF(2^8), reduced by x^8 + x^4 + x^3 + x + 1.

Next to the data path, each group gets a one-byte integrity signature. The signature is the XOR of all sixteen input bytes and all sixteen output bytes of that group. Every row of the matrix sums to one, so a fault-free group always yields a zero signature. A corrupted output byte shows up only in the signature of its own group. A summary flag reports whether any signature is nonzero.

A byte-wide fault port lets a test corrupt one output byte on purpose. The result can be captured in an output register under a valid strobe, or passed straight through when that register is disabled by parameter.

Top module: `wide_mixcol`

## Requirements
- R1: The byte at row r (0..3) and column c (0..63) occupies bits [8*(64*r+c) +: 8] of both `state_i` and `state_o`.
- R2: Each output column equals the MixColumns product of its input column, with matrix rows {2,3,1,1}, {1,2,3,1}, {1,1,2,3}, {3,1,1,2} over GF(2^8) modulo 0x11B. For example, input column (row 0..3) db,13,53,45 gives 8e,4d,a1,bc.
- R3: The signature for group j sits at `sig_o[8*j +: 8]`. Group j covers columns 4j..4j+3. The signature is the XOR of the 16 input bytes and 16 output bytes of that group. It is zero whenever `fault_byte_i` is zero.
- R4: `fault_byte_i` is XORed into the output byte whose index 64*r+c equals `fault_pos_i`. As a result, signature j = c/4 equals `fault_byte_i` and every other signature stays zero.
- R5: `err_o` is 1 exactly when at least one bit of `sig_o` is set.
- R6: With REG_OUT=1 (the default), state, signatures and error flag are all captured on a rising clock edge where `valid_i` is 1. `valid_o` follows `valid_i` one cycle later. While `valid_i` is 0, all outputs hold their values.
- R7: While `rst_ni` is low, `valid_o`, `state_o`, `sig_o` and `err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input state is valid; capture strobe |
| state_i | input | 2048 | Input state, byte (r,c) at 8*(64r+c) |
| fault_byte_i | input | 8 | XOR pattern injected into one output byte (0 = none) |
| fault_pos_i | input | 8 | Byte index 64r+c of the injected fault |
| valid_o | output | 1 | Output state is valid |
| state_o | output | 2048 | Mixed state, same layout as input |
| sig_o | output | 128 | Sixteen group signatures, group j at 8j |
| err_o | output | 1 | OR of all signature bits |

## Verification
The bench sends bytes with the top bit set, so a design that skips or misplaces the 0x1B reduction produces wrong columns. It also sends a known test column and a single lone byte, which catch a swapped matrix row or a transposed row/column layout.

Faults are injected into column 0, column 63 and mid-state groups. A wrong group boundary would then flag the neighbouring signature or leave the correct one at zero. A summary flag that ignored some groups would stay low.

Idle cycles with changing input data expose an output register that captures without the valid strobe.

// File: rtl/wide_mixcol_pkg.sv
package wide_mixcol_pkg;

  function automatic logic [7:0] gf_dbl(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  // column packed row 0 in [7:0] .. row 3 in [31:24]
  function automatic logic [31:0] mix_word(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    logic [31:0] m;
    a0 = w[7:0];
    a1 = w[15:8];
    a2 = w[23:16];
    a3 = w[31:24];
    m[7:0]   = gf_dbl(a0) ^ gf_dbl(a1) ^ a1 ^ a2 ^ a3;
    m[15:8]  = a0 ^ gf_dbl(a1) ^ gf_dbl(a2) ^ a2 ^ a3;
    m[23:16] = a0 ^ a1 ^ gf_dbl(a2) ^ gf_dbl(a3) ^ a3;
    m[31:24] = gf_dbl(a0) ^ a0 ^ a1 ^ a2 ^ gf_dbl(a3);
    return m;
  endfunction

endpackage

// File: rtl/wide_mixcol_column.sv
module wide_mixcol_column
  import wide_mixcol_pkg::*;
(
  input  logic [31:0] col_i,
  output logic [31:0] col_o
);
  assign col_o = mix_word(col_i);
endmodule

// File: rtl/wide_mixcol_group.sv
module wide_mixcol_group #(
  parameter int unsigned GRP_W = 4,
  localparam int unsigned GW = 32 * GRP_W
) (
  input  logic [GW-1:0] cols_i,
  input  logic [GW-1:0] flip_i,
  output logic [GW-1:0] cols_o,
  output logic [7:0]    sig_o
);
  logic [GW-1:0] mixed;

  for (genvar k = 0; k < GRP_W; k++) begin : g_col
    wide_mixcol_column u_col (
      .col_i(cols_i[32*k +: 32]),
      .col_o(mixed[32*k +: 32])
    );
  end

  assign cols_o = mixed ^ flip_i;

  always_comb begin
    sig_o = 8'h00;
    for (int b = 0; b < 4 * GRP_W; b++) begin
      sig_o ^= cols_i[8*b +: 8] ^ cols_o[8*b +: 8];
    end
  end
endmodule

// File: rtl/wide_mixcol_out_stage.sv
module wide_mixcol_out_stage #(
  parameter int unsigned W       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  output logic [W-1:0] q_o
);
  if (REG_OUT) begin : g_reg
    logic         valid_q;
    logic [W-1:0] q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        q_q     <= '0;
      end else begin
        valid_q <= valid_i;
        if (valid_i) q_q <= d_i;
      end
    end
    assign valid_o = valid_q;
    assign q_o     = q_q;
  end else begin : g_comb
    assign valid_o = valid_i;
    assign q_o     = d_i;
  end
endmodule

// File: rtl/wide_mixcol.sv
module wide_mixcol #(
  parameter int unsigned N_COLS  = 64,
  parameter int unsigned GRP_W   = 4,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned N_ROWS  = 4,
  localparam int unsigned N_GRP   = N_COLS / GRP_W,
  localparam int unsigned STATE_W = 8 * N_ROWS * N_COLS,
  localparam int unsigned SIG_W   = 8 * N_GRP,
  localparam int unsigned POS_W   = $clog2(N_ROWS * N_COLS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic [7:0]         fault_byte_i,
  input  logic [POS_W-1:0]   fault_pos_i,
  output logic               valid_o,
  output logic [STATE_W-1:0] state_o,
  output logic [SIG_W-1:0]   sig_o,
  output logic               err_o
);
  localparam int unsigned GW    = 32 * GRP_W;
  localparam int unsigned OUT_W = STATE_W + SIG_W + 1;

  logic [STATE_W-1:0]  flip;
  logic [STATE_W-1:0]  state_mix;
  logic [N_GRP*GW-1:0] grp_in, grp_flip, grp_out;
  logic [SIG_W-1:0]    sig_mix;
  logic                err_mix;

  always_comb begin
    flip = '0;
    flip[{fault_pos_i, 3'b000} +: 8] = fault_byte_i;
  end

  // regroup row-major flat state into column-major groups
  for (genvar j = 0; j < N_GRP; j++) begin : g_grp
    for (genvar k = 0; k < GRP_W; k++) begin : g_c
      for (genvar r = 0; r < N_ROWS; r++) begin : g_r
        localparam int unsigned FI = 8 * (N_COLS * r + GRP_W * j + k);
        localparam int unsigned GI = GW * j + 32 * k + 8 * r;
        assign grp_in[GI +: 8]    = state_i[FI +: 8];
        assign grp_flip[GI +: 8]  = flip[FI +: 8];
        assign state_mix[FI +: 8] = grp_out[GI +: 8];
      end
    end

    wide_mixcol_group #(.GRP_W(GRP_W)) u_grp (
      .cols_i(grp_in[GW*j +: GW]),
      .flip_i(grp_flip[GW*j +: GW]),
      .cols_o(grp_out[GW*j +: GW]),
      .sig_o (sig_mix[8*j +: 8])
    );
  end

  assign err_mix = |sig_mix;

  wide_mixcol_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .d_i    ({err_mix, sig_mix, state_mix}),
    .valid_o(valid_o),
    .q_o    ({err_o, sig_o, state_o})
  );
endmodule

// File: rtl/wide_mixcol_chk.sv
module wide_mixcol_chk #(
  parameter int unsigned STATE_W = 2048,
  parameter int unsigned SIG_W   = 128,
  parameter bit          REG_OUT = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [7:0]         fault_byte_i,
  input logic               valid_o,
  input logic [STATE_W-1:0] state_o,
  input logic [SIG_W-1:0]   sig_o,
  input logic               err_o
);
  localparam int unsigned N_GRP = SIG_W / 8;

  logic [N_GRP-1:0] grp_nz;
  always_comb begin
    for (int j = 0; j < N_GRP; j++) grp_nz[j] = |sig_o[8*j +: 8];
  end

  a_r4_single_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grp_nz));

  a_r5_err_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_o == '0) |-> !err_o);

  a_r5_err_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_o != '0) |-> err_o);

  if (REG_OUT) begin : g_reg
    a_r3_clean_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && fault_byte_i == 8'h00) |=> (sig_o == '0));

    a_r6_valid_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);

    a_r6_valid_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);

    a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> ($stable(state_o) && $stable(sig_o) && $stable(err_o)));

    a_r7_reset_clear: assert property (@(posedge clk_i)
      !rst_ni |-> (!valid_o && !err_o && sig_o == '0 && state_o == '0));
  end else begin : g_comb
    a_r3_clean_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && fault_byte_i == 8'h00) |-> (sig_o == '0));

    a_r6_valid_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |-> valid_o);
  end
endmodule

bind wide_mixcol wide_mixcol_chk #(
  .STATE_W(STATE_W),
  .SIG_W  (SIG_W),
  .REG_OUT(REG_OUT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .fault_byte_i(fault_byte_i),
  .valid_o     (valid_o),
  .state_o     (state_o),
  .sig_o       (sig_o),
  .err_o       (err_o)
);

// File: tb/wide_mixcol_test.sv
module wide_mixcol_test;
  localparam int SW = 2048;
  localparam int GW = 128;

  typedef struct packed {
    logic [SW-1:0] state;
    logic [GW-1:0] sig;
    logic          err;
  } item_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [SW-1:0] state_i = '0;
  logic [7:0]    fault_byte_i = 8'h00;
  logic [7:0]    fault_pos_i = 8'h00;
  logic          valid_o;
  logic [SW-1:0] state_o;
  logic [GW-1:0] sig_o;
  logic          err_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  item_t exp_q[$];
  item_t last_exp;

  always #5 clk_i = ~clk_i;

  wide_mixcol uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .state_i(state_i),
    .fault_byte_i(fault_byte_i), .fault_pos_i(fault_pos_i),
    .valid_o(valid_o), .state_o(state_o), .sig_o(sig_o), .err_o(err_o)
  );

  function automatic logic [7:0] m2(input logic [7:0] x);
    return (x << 1) ^ ((x & 8'h80) != 0 ? 8'h1b : 8'h00);
  endfunction

  function automatic item_t model(input logic [SW-1:0] din, input logic [7:0] fb,
                                  input logic [7:0] fp);
    item_t it;
    logic [7:0] a [4];
    it = '0;
    for (int c = 0; c < 64; c++) begin
      for (int r = 0; r < 4; r++) a[r] = din[8*(64*r+c) +: 8];
      it.state[8*c +: 8]         = m2(a[0]) ^ m2(a[1]) ^ a[1] ^ a[2] ^ a[3];
      it.state[8*(64+c) +: 8]    = a[0] ^ m2(a[1]) ^ m2(a[2]) ^ a[2] ^ a[3];
      it.state[8*(128+c) +: 8]   = a[0] ^ a[1] ^ m2(a[2]) ^ m2(a[3]) ^ a[3];
      it.state[8*(192+c) +: 8]   = m2(a[0]) ^ a[0] ^ a[1] ^ a[2] ^ m2(a[3]);
    end
    it.state[8*fp +: 8] = it.state[8*fp +: 8] ^ fb;
    for (int j = 0; j < 16; j++)
      for (int c = 4*j; c < 4*j+4; c++)
        for (int r = 0; r < 4; r++)
          it.sig[8*j +: 8] = it.sig[8*j +: 8] ^ din[8*(64*r+c) +: 8]
                             ^ it.state[8*(64*r+c) +: 8];
    it.err = |it.sig;
    return it;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare_item(input item_t e);
    int first = -1;
    for (int b = 0; b < 256; b++)
      if (first < 0 && state_o[8*b +: 8] !== e.state[8*b +: 8]) first = b;
    if (first < 0) check(1'b1, "R2", '0, '0);
    else check(1'b0, $sformatf("R2 state byte %0d", first),
               128'(state_o[8*first +: 8]), 128'(e.state[8*first +: 8]));
    check(sig_o === e.sig, "R3/R4 signatures", sig_o, e.sig);
    check(err_o === e.err, "R5 summary", 128'(err_o), 128'(e.err));
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (rst_ni && valid_o) begin
        if (exp_q.size() == 0) check(1'b0, "R6 unexpected valid_o", 1, 0);
        else begin
          item_t e;
          e = exp_q.pop_front();
          last_exp = e;
          compare_item(e);
        end
      end
    end
  end

  task automatic send(input logic [SW-1:0] din, input logic [7:0] fb, input logic [7:0] fp);
    @(negedge clk_i);
    valid_i = 1'b1;
    state_i = din;
    fault_byte_i = fb;
    fault_pos_i = fp;
    exp_q.push_back(model(din, fb, fp));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      state_i = {64{$urandom()}};
      fault_byte_i = 8'h00;
    end
  endtask

  function automatic logic [SW-1:0] rnd_state();
    logic [SW-1:0] s;
    for (int w = 0; w < 64; w++) s[32*w +: 32] = $urandom();
    return s;
  endfunction

  initial begin
    logic [SW-1:0] d;
    #20;
    check(valid_o === 1'b0 && err_o === 1'b0, "R7 valid/err in reset",
          128'({valid_o, err_o}), 0);
    check(state_o === '0 && sig_o === '0, "R7 state/sig in reset",
          sig_o, 0);
    #12 rst_ni = 1'b1;

    // R1: lone byte at row 1, column 5
    d = '0;
    d[8*(64*1+5) +: 8] = 8'h01;
    send(d, 8'h00, 8'h00);
    idle(1);
    check(state_o[8*5 +: 8] == 8'h03 && state_o[8*69 +: 8] == 8'h02 &&
          state_o[8*133 +: 8] == 8'h01 && state_o[8*197 +: 8] == 8'h01,
          "R1 lone byte column",
          {state_o[8*197 +: 8], state_o[8*133 +: 8], state_o[8*69 +: 8], state_o[8*5 +: 8]},
          32'h01010203);

    // R2: known column vector in column 0
    d = '0;
    d[8*0 +: 8] = 8'hdb; d[8*64 +: 8] = 8'h13;
    d[8*128 +: 8] = 8'h53; d[8*192 +: 8] = 8'h45;
    send(d, 8'h00, 8'h00);
    idle(1);
    check({state_o[8*192 +: 8], state_o[8*128 +: 8], state_o[8*64 +: 8], state_o[7:0]}
          == 32'hbca14d8e, "R2 known column",
          {state_o[8*192 +: 8], state_o[8*128 +: 8], state_o[8*64 +: 8], state_o[7:0]},
          32'hbca14d8e);

    // R2 reduction corners, back to back
    send('0, 8'h00, 8'h00);
    send({256{8'hff}}, 8'h00, 8'h00);
    send({256{8'h80}}, 8'h00, 8'h00);
    for (int b = 0; b < 256; b++) d[8*b +: 8] = 8'(b);
    send(d, 8'h00, 8'h00);
    for (int i = 0; i < 12; i++) send(rnd_state(), 8'h00, 8'h00);

    // R4: fault injection at edges and middle
    send(rnd_state(), 8'h5a, 8'(0));
    send(rnd_state(), 8'h01, 8'(64*3+63));
    send(rnd_state(), 8'hc3, 8'(64*2+37));
    for (int i = 0; i < 6; i++)
      send(rnd_state(), 8'($urandom_range(1, 255)), 8'($urandom_range(0, 255)));
    d = rnd_state();
    send(d, 8'h80, 8'(64*1+20));
    idle(2);
    check(sig_o[8*5 +: 8] == 8'h80 && (sig_o & ~({120'h0, 8'hff} << 40)) == '0,
          "R4 group 5 only", sig_o, 128'h80 << 40);

    // R6: outputs hold while valid_i is low and input changes
    idle(3);
    check(valid_o === 1'b0, "R6 valid_o low when idle", 128'(valid_o), 0);
    check(state_o === last_exp.state && sig_o === last_exp.sig, "R6 hold",
          sig_o, last_exp.sig);

    idle(2);
    check(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule